// File: doc/BRIEF.md
# Parallel-to-Serial Interrupt Converter

This block takes eleven active-high legacy interrupt request lines (IRQ3, IRQ4, IRQ5, IRQ6, IRQ7, IRQ9, IRQ10, IRQ11, IRQ12, IRQ14 and IRQ15) and reports them on one shared, open-drain serial interrupt line. The line runs on the PCI clock and is pulled up externally. Each frame on the line has three parts: a start pulse, sixteen three-clock slots, and a stop pulse driven by the host. In the first clock of slot n, the block pulls the line low when IRQn is asserted and enabled. The block never drives slots 0, 1, 2, 8 and 13.

Two byte-wide mask registers, written through a simple strobe, can disable each interrupt. A disabled interrupt is always reported as inactive. The block watches the length of each stop pulse to choose its mode. In continuous mode it only answers frames that the host starts. In quiet mode it may start a frame itself when an enabled input changes while the line is idle.

Top module: `sirq_serializer`

## Requirements
- R1: A slot begins every 3 clocks. The sample clock of the slot for IRQn is the clock 3×n clocks after the first clock on which the line is seen high again after a start pulse. In that clock the block pulls the line low (sirq_oe=1, sirq_o=0) exactly when IRQn is asserted and enabled. It leaves the sample clocks of slots 0, 1, 2, 8 and 13 undriven.
- R2: In the clock after each slot pull, the block drives the line high for exactly one clock (sirq_oe=1, sirq_o=1). In the third clock of the slot it releases the line. It never drives the line high at any other time.
- R3: Writing with cfg_sel=0 loads mask register A. Bits 7..0 of A disable, in order, IRQ11, IRQ10, IRQ9, IRQ7, IRQ6, IRQ5, IRQ4 and IRQ3 when set to 1. The register reads back in full on mask_a_rd.
- R4: Writing with cfg_sel=1 loads mask register B. Its bits 2, 1 and 0 disable IRQ15, IRQ14 and IRQ12 when set to 1. Bits 7..3 of mask_b_rd always read 0.
- R5: A synchronous reset (rst_n low at a rising edge) clears both mask registers to 00h, releases the line and selects continuous mode.
- R6: A start pulse needs at least 4 consecutive low clocks followed by a high clock. A shorter low pulse starts no frame.
- R7: After the 16 slots, a host stop pulse of 2 low clocks selects quiet mode. A stop pulse of 3 low clocks selects continuous mode.
- R8: In quiet mode, a change on an enabled input while the line is idle makes the block pull the line low for START_LEN clocks (default 4, allowed range 4 to 8). The block then serves the frame that follows.
- R9: In continuous mode the block never starts a frame. In quiet mode a change on a disabled input starts no frame.
- R10: Each input passes through two synchroniser flops. A quiet-mode start pulse therefore begins on the third clock after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock; all logic samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 11 | Parallel requests; bits 0..10 = IRQ3,4,5,6,7,9,10,11,12,14,15 |
| cfg_wr | input | 1 | Mask register write strobe |
| cfg_sel | input | 1 | Register select: 0 = mask A, 1 = mask B |
| cfg_wdata | input | 8 | Write data |
| mask_a_rd | output | 8 | Current value of mask register A |
| mask_b_rd | output | 8 | Current value of mask register B (bits 7..3 zero) |
| sirq_in | input | 1 | Sampled level of the shared serial line |
| sirq_oe | output | 1 | Drive enable for the serial line pad |
| sirq_o | output | 1 | Value driven when sirq_oe is 1 |

## Verification
The bench captures whole frames clock by clock and compares every slot. A slot counter that is off by one clock, or a wrong map from input to slot, would pull the line in a neighbouring slot. The bench writes mask patterns that split across both registers. A reversed or shifted bit order would then let a disabled interrupt through or silence an enabled one. A read of all ones from register B would expose stored reserved bits. A three-clock low pulse must start no frame, and stop pulses of two and three clocks must switch the mode. A design that counted these lengths wrongly would start frames in continuous mode or stay silent in quiet mode. The bench also measures the delay from an input change to a self-started pulse, and the length of that pulse. A missing synchroniser stage or a wrong pulse count shows up as a wrong delay or length.

// File: rtl/sirq_pkg.sv
// Package: shared constants, state type and the input-to-slot map for the
// serial interrupt converter. Assumes the fixed sparse set of eleven inputs.
package sirq_pkg;

    localparam int N_IRQ      = 11;
    localparam int N_SLOTS    = 16;
    localparam int SLOT_W     = $clog2(N_SLOTS);
    localparam int START_MIN  = 4;
    localparam int LOWCNT_W   = 4;
    localparam int STOP_QUIET = 2;
    localparam int STOP_CONT  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOTS = 2'd1,
        ST_STOP  = 2'd2
    } seq_state_t;

    // Slot number carried by input bit i (bit 0 = IRQ3 ... bit 10 = IRQ15).
    function automatic logic [SLOT_W-1:0] slot_of(input int i);
        case (i)
            0:       slot_of = 4'd3;
            1:       slot_of = 4'd4;
            2:       slot_of = 4'd5;
            3:       slot_of = 4'd6;
            4:       slot_of = 4'd7;
            5:       slot_of = 4'd9;
            6:       slot_of = 4'd10;
            7:       slot_of = 4'd11;
            8:       slot_of = 4'd12;
            9:       slot_of = 4'd14;
            default: slot_of = 4'd15;
        endcase
    endfunction

endpackage

// File: rtl/sirq_in_sync.sv
// Module: multi-flop synchroniser for a vector of asynchronous request lines.
// Assumes the inputs are level signals that stay stable for several clocks.
module sirq_in_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg [STAGES];

    // Shift the requests through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/sirq_mask_regs.sv
// Module: two disable-mask registers with a simple write strobe.
// A holds IRQ11..IRQ3 (excluding IRQ8) and B bits 2..0 hold IRQ15, IRQ14, IRQ12.
// Assumes one write per strobe cycle; bits 7..3 of B are not stored.
module sirq_mask_regs
    import sirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [7:0]       wdata,
    output logic [7:0]       mask_a,
    output logic [7:0]       mask_b,
    output logic [N_IRQ-1:0] irq_en
);

    logic [7:0] a_q;
    logic [2:0] b_q;

    // Capture mask writes; reset enables every interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (wr) begin
            if (sel) b_q <= wdata[2:0];
            else     a_q <= wdata;
        end
    end

    assign mask_a = a_q;
    assign mask_b = {5'b0, b_q};
    assign irq_en = ~{b_q, a_q};

endmodule

// File: rtl/sirq_frame_seq.sv
// Module: frame sequencer. It watches the shared line for start and stop
// pulses, walks the sixteen 3-clock slots, pulls the line in its own slots,
// and starts a frame itself in quiet mode. Assumes the line is sampled on
// every rising edge and pulled up externally.
module sirq_frame_seq
    import sirq_pkg::*;
#(
    parameter int START_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_s,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             line_i,
    output logic             drv_low,
    output logic             drv_high
);

    localparam logic [LOWCNT_W-1:0] START_LEN_C = LOWCNT_W'(START_LEN);
    localparam logic [LOWCNT_W-1:0] START_MIN_C = LOWCNT_W'(START_MIN);
    localparam logic [LOWCNT_W-1:0] LOW_SAT     = '1;
    localparam logic [SLOT_W-1:0]   LAST_SLOT   = SLOT_W'(N_SLOTS - 1);

    seq_state_t          state;
    logic [SLOT_W-1:0]   slot_idx;
    logic [1:0]          phase;
    logic [LOWCNT_W-1:0] low_cnt;
    logic [LOWCNT_W-1:0] start_cnt;
    logic                quiet;
    logic                pend;
    logic                pulled_q;
    logic [N_IRQ-1:0]    irq_prev;

    logic [N_SLOTS-1:0]  slot_vec;
    logic                pull_slot;
    logic                chg;
    logic                line_idle;
    logic                kick;
    logic                enter_slots;

    // Place each enabled, asserted request on its slot position.
    always_comb begin
        slot_vec = '0;
        for (int i = 0; i < N_IRQ; i++)
            slot_vec[slot_of(i)] = irq_s[i] & irq_en[i];
    end

    // Decode pull, change and start conditions from the current state.
    always_comb begin
        pull_slot   = (state == ST_SLOTS) && (phase == 2'd0) && slot_vec[slot_idx];
        chg         = |((irq_s ^ irq_prev) & irq_en);
        line_idle   = line_i && (low_cnt == '0) && (start_cnt == '0);
        kick        = (state == ST_IDLE) && quiet && line_idle && (chg || pend);
        enter_slots = (state == ST_IDLE) && line_i && (low_cnt >= START_MIN_C);
    end

    // Frame tracking, mode selection and self-start control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            slot_idx  <= '0;
            phase     <= '0;
            low_cnt   <= '0;
            start_cnt <= '0;
            quiet     <= 1'b0;
            pend      <= 1'b0;
            pulled_q  <= 1'b0;
            irq_prev  <= '0;
        end else begin
            irq_prev <= irq_s;
            pulled_q <= pull_slot;
            low_cnt  <= line_i ? '0 : ((low_cnt == LOW_SAT) ? LOW_SAT : low_cnt + 1'b1);

            if (kick)                 start_cnt <= START_LEN_C;
            else if (start_cnt != '0) start_cnt <= start_cnt - 1'b1;

            if (!quiet || kick || enter_slots) pend <= 1'b0;
            else if (chg)                      pend <= 1'b1;

            case (state)
                ST_IDLE: begin
                    if (enter_slots) begin
                        state    <= ST_SLOTS;
                        slot_idx <= '0;
                        phase    <= '0;
                    end
                end
                ST_SLOTS: begin
                    if (phase == 2'd2) begin
                        phase <= '0;
                        if (slot_idx == LAST_SLOT) state <= ST_STOP;
                        else                       slot_idx <= slot_idx + 1'b1;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (line_i && (low_cnt != '0)) begin
                        if (low_cnt == LOWCNT_W'(STOP_QUIET))     quiet <= 1'b1;
                        else if (low_cnt == LOWCNT_W'(STOP_CONT)) quiet <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign drv_low  = pull_slot || (start_cnt != '0);
    assign drv_high = pulled_q;

endmodule

// File: rtl/sirq_serializer.sv
// Module: top of the parallel-to-serial interrupt converter. It joins the
// synchroniser, the mask registers and the frame sequencer, and forms the
// open-drain pad controls. Assumes an external pull-up on the serial line.
module sirq_serializer
    import sirq_pkg::*;
#(
    parameter int START_LEN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       mask_a_rd,
    output logic [7:0]       mask_b_rd,
    input  logic             sirq_in,
    output logic             sirq_oe,
    output logic             sirq_o
);

    logic [N_IRQ-1:0] irq_s;
    logic [N_IRQ-1:0] irq_en;
    logic             drv_low;
    logic             drv_high;

    sirq_in_sync #(.W(N_IRQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_req),
        .sync_o  (irq_s)
    );

    sirq_mask_regs u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .mask_a (mask_a_rd),
        .mask_b (mask_b_rd),
        .irq_en (irq_en)
    );

    sirq_frame_seq #(.START_LEN(START_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_s    (irq_s),
        .irq_en   (irq_en),
        .line_i   (sirq_in),
        .drv_low  (drv_low),
        .drv_high (drv_high)
    );

    // Open-drain pad: the block pulls low, drives high for one recovery clock, or floats.
    assign sirq_oe = drv_low | drv_high;
    assign sirq_o  = drv_high & ~drv_low;

endmodule

// File: rtl/sirq_serializer_chk.sv
// Module: property checker for the serial interrupt converter, attached by bind.
// Assumes START_LEN matches the design's parameter.
module sirq_serializer_chk #(
    parameter int START_LEN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       cfg_sel,
    input logic [7:0] cfg_wdata,
    input logic [7:0] mask_a_rd,
    input logic [7:0] mask_b_rd,
    input logic       sirq_oe,
    input logic       sirq_o
);

    logic       pull;
    logic [4:0] run;

    assign pull = sirq_oe && !sirq_o;

    // Length of the current low-drive run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          run <= '0;
        else if (pull)       run <= (run == 5'd31) ? run : run + 1'b1;
        else                 run <= '0;
    end

    // R2: a high drive only follows a pull-low clock.
    p_high_after_pull_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && sirq_o) |-> $past(sirq_oe && !sirq_o))
        else $error("p_high_after_pull_r2");

    // R2: the high drive lasts a single clock.
    p_high_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && sirq_o) |=> !(sirq_oe && sirq_o))
        else $error("p_high_one_clk_r2");

    // R8: every low-drive run is either a slot pull or a full start pulse.
    p_run_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pull && run != 5'd0) |-> (run == 5'd1 || run == 5'(START_LEN)))
        else $error("p_run_len_r8");

    // R3: a write to register A is visible on the next clock.
    p_write_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel) |=> (mask_a_rd == $past(cfg_wdata)))
        else $error("p_write_a_r3");

    // R4: a write to register B keeps only its low three bits.
    p_write_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel) |=> (mask_b_rd == {5'b0, $past(cfg_wdata[2:0])}))
        else $error("p_write_b_r4");

    // R5: a reset edge leaves the line released and the masks clear.
    p_reset_state_r5: assert property (@(posedge clk)
        !rst_n |=> (!sirq_oe && mask_a_rd == 8'h00 && mask_b_rd == 8'h00))
        else $error("p_reset_state_r5");

endmodule

bind sirq_serializer sirq_serializer_chk #(.START_LEN(START_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .mask_a_rd (mask_a_rd),
    .mask_b_rd (mask_b_rd),
    .sirq_oe   (sirq_oe),
    .sirq_o    (sirq_o)
);

// File: tb/sim_sirq_serializer.sv
// Bench: directed scenarios, one task each; acts as host on the serial line.
module sim_sirq_serializer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] irq_req = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  mask_a_rd;
    logic [7:0]  mask_b_rd;
    logic        sirq_oe;
    logic        sirq_o;
    logic        host_low = 1'b0;
    logic        line;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] mA = 8'h00;
    logic [7:0] mB = 8'h00;
    logic       rec_line [48];
    logic       rec_oe   [48];
    logic       rec_o    [48];

    always #2 clk = ~clk;

    assign line = ~((sirq_oe & ~sirq_o) | host_low);

    sirq_serializer u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mask_a_rd(mask_a_rd), .mask_b_rd(mask_b_rd),
        .sirq_in(line), .sirq_oe(sirq_oe), .sirq_o(sirq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_num(input int i);
        int t [11] = '{3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15};
        return t[i];
    endfunction

    // Expected slot pulls: bits 0..7 of A guard inputs 0..7, bits 0..2 of B guard inputs 8..10.
    function automatic logic [15:0] exp_slots();
        logic [15:0] e = '0;
        logic [10:0] dis = {mB[2:0], mA};
        for (int i = 0; i < 11; i++)
            if (irq_req[i] && !dis[i]) e[slot_num(i)] = 1'b1;
        return e;
    endfunction

    task automatic wr_reg(input bit sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sel) mB = {5'b0, d[2:0]}; else mA = d;
    endtask

    // Called at the negedge where the line is first high after a start pulse.
    task automatic capture_frame();
        for (int k = 0; k < 48; k++) begin
            @(negedge clk);
            rec_line[k] = line; rec_oe[k] = sirq_oe; rec_o[k] = sirq_o;
        end
    endtask

    task automatic check_frame(input logic [15:0] e);
        for (int s = 0; s < 16; s++) begin
            chk(rec_line[3*s] == !e[s], $sformatf("R1 slot %0d", s), rec_line[3*s], !e[s]);
            if (e[s]) begin
                chk(rec_oe[3*s+1] && rec_o[3*s+1], $sformatf("R2 recovery slot %0d", s),
                    {rec_oe[3*s+1], rec_o[3*s+1]}, 2'b11);
                chk(!rec_oe[3*s+2], $sformatf("R2 release slot %0d", s), rec_oe[3*s+2], 0);
            end else begin
                chk(!rec_oe[3*s], $sformatf("R1 idle slot %0d", s), rec_oe[3*s], 0);
            end
        end
    endtask

    task automatic host_frame(input int start_len);
        @(negedge clk);
        host_low = 1'b1;
        repeat (start_len) @(negedge clk);
        host_low = 1'b0;
        capture_frame();
    endtask

    task automatic host_stop(input int len);
        @(negedge clk);
        host_low = 1'b1;
        repeat (len) @(negedge clk);
        host_low = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_silent(input int cycles, input string req);
        int seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (sirq_oe) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mask_a_rd == 8'h00, "R5 mask A reset", mask_a_rd, 0);
        chk(mask_b_rd == 8'h00, "R5 mask B reset", mask_b_rd, 0);
        chk(!sirq_oe, "R5 line released", sirq_oe, 0);
    endtask

    task automatic t_mask_regs();
        wr_reg(1'b0, 8'hA5);
        @(negedge clk);
        chk(mask_a_rd == 8'hA5, "R3 mask A readback", mask_a_rd, 8'hA5);
        wr_reg(1'b1, 8'hFF);
        @(negedge clk);
        chk(mask_b_rd == 8'h07, "R4 mask B reserved zero", mask_b_rd, 8'h07);
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_frame_sparse();
        irq_req = 11'b100_0010_0001;   // IRQ3, IRQ9, IRQ15
        repeat (4) @(negedge clk);
        host_frame(4);
        check_frame(exp_slots());
        host_stop(3);
    endtask

    task automatic t_frame_masked();
        irq_req = '1;
        wr_reg(1'b0, 8'h81);           // disable IRQ11 and IRQ3
        wr_reg(1'b1, 8'h02);           // disable IRQ14
        repeat (3) @(negedge clk);
        host_frame(6);
        check_frame(exp_slots());
        chk(rec_line[9] && rec_line[33] && rec_line[42], "R3 R4 masked slots high",
            {rec_line[9], rec_line[33], rec_line[42]}, 3'b111);
        host_stop(3);
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_short_start();
        irq_req = 11'b000_0000_0001;
        repeat (3) @(negedge clk);
        @(negedge clk);
        host_low = 1'b1;
        repeat (3) @(negedge clk);
        host_low = 1'b0;
        expect_silent(60, "R6 short start ignored");
    endtask

    task automatic t_continuous_no_start();
        irq_req = irq_req ^ 11'b000_0000_0010;
        expect_silent(15, "R9 continuous no self start");
    endtask

    task automatic t_quiet_start();
        int lat = 0;
        int run = 0;
        irq_req = 11'b000_0001_0000;   // IRQ7
        repeat (3) @(negedge clk);
        host_frame(4);
        host_stop(2);
        irq_req = 11'b000_0001_0100;   // add IRQ5: change on enabled input
        for (int k = 1; k <= 10 && lat == 0; k++) begin
            @(negedge clk);
            if (sirq_oe) lat = k;
        end
        chk(lat == 3, "R10 start latency", lat, 3);
        run = 1;
        while (sirq_oe && run < 12) begin
            @(negedge clk);
            if (sirq_oe) run++;
        end
        chk(run == 4, "R8 start pulse length", run, 4);
        capture_frame();
        check_frame(exp_slots());
        host_stop(2);
    endtask

    task automatic t_quiet_masked();
        wr_reg(1'b1, 8'h04);           // disable IRQ15
        repeat (3) @(negedge clk);
        irq_req = irq_req | 11'b100_0000_0000;
        expect_silent(15, "R9 masked change no start");
    endtask

    task automatic t_stop_continuous();
        host_frame(4);
        check_frame(exp_slots());
        host_stop(3);
        irq_req = irq_req ^ 11'b000_0000_0001;
        expect_silent(15, "R7 stop of 3 selects continuous");
    endtask

    initial begin
        t_reset();
        t_mask_regs();
        t_frame_sparse();
        t_frame_masked();
        t_short_start();
        t_continuous_no_start();
        t_quiet_start();
        t_quiet_masked();
        t_stop_continuous();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule